// File: doc/BRIEF.md
# Carrier-Sense Collision Backoff Controller

This block decides when a station on a shared serial bus may start a frame. The bus is wired-AND: a station actively drives only Space (0), and pull resistors return the line to Mark (1). The controller watches the received line level and sets a grant once the line has rested at Mark for long enough. While the grant is high, it compares the level it reads back with the bit the local UART transmitter is sending, at every bit tick.

A mismatch means that another station is also driving the line. The controller then drops the grant, pulses an abort and waits a pseudo-random number of backoff slots. The range of that number doubles with each consecutive collision, up to a cap. A free-running counter measures the time since reset, and it seeds a 16-bit LFSR on the first collision of a series. Because of this, stations that started at different moments pick different delays.

A completed frame clears the collision count. After a run of sixteen consecutive collisions the controller reports a failure and starts over with a cleared count.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `frm_grant`, `frm_abort` and `frm_fail` are all 0.
- R2: `frm_grant` rises only when `frm_req` is 1 and the line was sampled at Mark (1) on at least 11 consecutive bit ticks since the last Space and since the last grant ended. It never rises while `frm_req` is 0.
- R3: A Space (0) sampled on `rx_bit` at any bit tick restarts the Mark run, so a fresh run of 11 Mark ticks is needed before a grant.
- R4: A collision is a bit tick during the grant at which `rx_bit` differs from `tx_bit`. On the next cycle `frm_grant` is 0 and `frm_abort` is 1 for exactly one cycle.
- R5: No abort is raised while the read-back level equals the sent level. This includes Space sent by the station and read back as Space while another station also drives Space.
- R6: After the n-th consecutive collision (n < 16), the controller waits r slots of 12 bit ticks each, with r in 0 to 2^min(n,8) − 1, chosen from the LFSR. If the line stays at Mark, the re-grant comes after max(12·r, 11) bit ticks.
- R7: A `frm_done` pulse during the grant ends the grant on the next cycle and clears the collision count, so the next collision uses the range 0 to 1.
- R8: The 16th consecutive collision pulses `frm_fail` together with `frm_abort`, clears the collision count and skips the backoff. A pending request is then granted after exactly 11 Mark ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse marking the sample point of each bit time |
| frm_req | input | 1 | Station has a frame waiting |
| frm_done | input | 1 | UART pulse: frame sent completely |
| tx_bit | input | 1 | Level the UART is sending (1 = Mark) |
| rx_bit | input | 1 | Level read back from the bus |
| frm_grant | output | 1 | UART may transmit while high |
| frm_abort | output | 1 | One-cycle pulse: collision, stop sending |
| frm_fail | output | 1 | One-cycle pulse: retry limit reached |

## Verification
The hardest state to reach from the ports is the sixteenth consecutive collision. Reaching it takes fifteen backoffs in a row, each of random length, and the last of them can span thousands of ticks. The bench reaches it by holding the request high and forcing Space on the bus at a Mark bit of every grant. It does this sixteen times without a completed frame in between. Its model tracks the collision count, so it can predict the widening window, the fail pulse and the fixed 11-tick re-grant that follows.

// File: rtl/csma_pkg.sv
package csma_pkg;
   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_SEND = 2'd1,
      ST_HOLD = 2'd2
   } csma_state_e;
endpackage

// File: rtl/csma_carrier_sense.sv
module csma_carrier_sense #(
   parameter int unsigned IDLE_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic rx_bit,
   input  logic own_tx,
   output logic line_idle
);
   localparam int unsigned CW = $clog2(IDLE_BITS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

   if (IDLE_BITS < 1) begin : g_bad_idle
      $error("IDLE_BITS must be at least 1");
   end

   logic [CW-1:0] mark_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_run <= '0;
      end else if (own_tx) begin
         mark_run <= '0;
      end else if (bit_tick) begin
         if (!rx_bit)
            mark_run <= '0;
         else if (mark_run != LIMIT)
            mark_run <= mark_run + 1'b1;
      end
   end

   assign line_idle = (mark_run == LIMIT);

   // R3: a sampled Space leaves the line busy on the next cycle
   a_r3_space_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && !rx_bit) |=> !line_idle);

   // R2: the idle flag only appears right after a Mark tick
   a_r2_idle_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_idle) |-> $past(bit_tick && rx_bit && !own_tx));
endmodule

// File: rtl/csma_backoff_rng.sv
module csma_backoff_rng #(
   parameter int unsigned SEED_W  = 16,
   parameter int unsigned EXP_MAX = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seed_now,
   output logic [EXP_MAX-1:0] rnd
);
   if (EXP_MAX < 1 || EXP_MAX > SEED_W) begin : g_bad_exp
      $error("EXP_MAX must lie in 1..SEED_W");
   end

   logic [SEED_W-1:0] uptime;
   logic [SEED_W-1:0] lfsr;
   logic [SEED_W-1:0] seed_val;
   logic              fb;

   if (SEED_W == 16) begin : g_taps16
      assign fb = lfsr[15] ^ lfsr[14] ^ lfsr[12] ^ lfsr[3];
   end else if (SEED_W == 8) begin : g_taps8
      assign fb = lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];
   end else if (SEED_W == 32) begin : g_taps32
      assign fb = lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0];
   end else begin : g_bad_width
      $error("SEED_W must be 8, 16 or 32");
      assign fb = 1'b0;
   end

   assign seed_val = (uptime == '0) ? SEED_W'(1) : uptime;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uptime <= '0;
         lfsr   <= SEED_W'(1);
      end else begin
         uptime <= uptime + 1'b1;
         if (seed_now)
            lfsr <= seed_val;
         else
            lfsr <= {lfsr[SEED_W-2:0], fb};
      end
   end

   assign rnd = seed_now ? seed_val[EXP_MAX-1:0] : lfsr[EXP_MAX-1:0];

   // R6: the generator never locks up in the all-zero state
   a_r6_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);
endmodule

// File: rtl/csma_backoff_timer.sv
module csma_backoff_timer #(
   parameter int unsigned SLOT_BITS = 12,
   parameter int unsigned EXP_MAX   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_tick,
   input  logic               start,
   input  logic [EXP_MAX-1:0] slots_in,
   output logic               busy
);
   localparam int unsigned BW = $clog2(SLOT_BITS + 1);
   localparam logic [BW-1:0] SLOT_LEN = BW'(SLOT_BITS);

   if (SLOT_BITS < 1) begin : g_bad_slot
      $error("SLOT_BITS must be at least 1");
   end

   logic [EXP_MAX-1:0] slot_left;
   logic [BW-1:0]      bit_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_left <= '0;
         bit_left  <= SLOT_LEN;
      end else if (start) begin
         slot_left <= slots_in;
         bit_left  <= SLOT_LEN;
      end else if (slot_left != '0 && bit_tick) begin
         if (bit_left == BW'(1)) begin
            bit_left  <= SLOT_LEN;
            slot_left <= slot_left - 1'b1;
         end else begin
            bit_left <= bit_left - 1'b1;
         end
      end
   end

   assign busy = (slot_left != '0);

   // R6: a wait can only end on a bit tick, never between ticks
   a_r6_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(start)) |-> $past(bit_tick));
endmodule

// File: rtl/csma_backoff_ctrl.sv
module csma_backoff_ctrl #(
   parameter int unsigned IDLE_BITS = 11,
   parameter int unsigned SLOT_BITS = 12,
   parameter int unsigned EXP_MAX   = 8,
   parameter int unsigned MAX_TRIES = 16,
   parameter int unsigned SEED_W    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic frm_req,
   input  logic frm_done,
   input  logic tx_bit,
   input  logic rx_bit,
   output logic frm_grant,
   output logic frm_abort,
   output logic frm_fail
);
   import csma_pkg::*;

   localparam int unsigned CNT_W = $clog2(MAX_TRIES + 1);
   localparam logic [CNT_W-1:0] LAST_TRY = CNT_W'(MAX_TRIES - 1);

   if (MAX_TRIES < 2) begin : g_bad_tries
      $error("MAX_TRIES must be at least 2");
   end

   csma_state_e        state;
   logic [CNT_W-1:0]   coll_cnt;
   logic [CNT_W-1:0]   new_cnt;
   logic [EXP_MAX-1:0] slot_mask;
   logic [EXP_MAX-1:0] rnd;
   logic               line_idle;
   logic               bo_busy;
   logic               collide;
   logic               last_try;
   logic               bo_start;
   logic               seed_now;
   logic               abort_q;
   logic               fail_q;

   assign collide  = (state == ST_SEND) && bit_tick && (rx_bit != tx_bit);
   assign last_try = (coll_cnt == LAST_TRY);
   assign new_cnt  = coll_cnt + 1'b1;
   assign bo_start = collide && !last_try;
   assign seed_now = collide && (coll_cnt == '0);

   for (genvar i = 0; i < int'(EXP_MAX); i++) begin : g_mask
      assign slot_mask[i] = (int'(new_cnt) > i);
   end

   csma_carrier_sense #(.IDLE_BITS(IDLE_BITS)) u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .rx_bit    (rx_bit),
      .own_tx    (state == ST_SEND),
      .line_idle (line_idle)
   );

   csma_backoff_rng #(.SEED_W(SEED_W), .EXP_MAX(EXP_MAX)) u_rng (
      .clk      (clk),
      .rst_n    (rst_n),
      .seed_now (seed_now),
      .rnd      (rnd)
   );

   csma_backoff_timer #(.SLOT_BITS(SLOT_BITS), .EXP_MAX(EXP_MAX)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .start    (bo_start),
      .slots_in (rnd & slot_mask),
      .busy     (bo_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_WAIT;
         coll_cnt <= '0;
         abort_q  <= 1'b0;
         fail_q   <= 1'b0;
      end else begin
         abort_q <= collide;
         fail_q  <= collide && last_try;
         unique case (state)
            ST_WAIT: if (frm_req && line_idle) state <= ST_SEND;
            ST_SEND: begin
               if (collide) begin
                  state    <= last_try ? ST_WAIT : ST_HOLD;
                  coll_cnt <= last_try ? '0 : new_cnt;
               end else if (frm_done) begin
                  state    <= ST_WAIT;
                  coll_cnt <= '0;
               end
            end
            ST_HOLD: if (!bo_busy) state <= ST_WAIT;
            default: state <= ST_WAIT;
         endcase
      end
   end

   assign frm_grant = (state == ST_SEND);
   assign frm_abort = abort_q;
   assign frm_fail  = fail_q;

   // R4: an abort never overlaps a grant
   a_r4_abort_ends_grant: assert property (@(posedge clk) disable iff (!rst_n)
      frm_abort |-> !frm_grant);

   // R2: a grant needs an idle line and a request on the cycle before
   a_r2_grant_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_grant) |-> $past(line_idle && frm_req));

   // R8: a failure is always reported together with its abort
   a_r8_fail_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
      frm_fail |-> frm_abort);

   // R8: the retry count stays below the limit
   a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      coll_cnt < CNT_W'(MAX_TRIES));

   // R7: a finished frame releases the bus on the next cycle
   a_r7_done_ends_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_grant && frm_done && !collide) |=> (!frm_grant && coll_cnt == '0));
endmodule

// File: tb/csma_backoff_ctrl_tb.sv
module csma_backoff_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0;
   logic frm_req = 1'b0;
   logic frm_done = 1'b0;
   logic tx_bit = 1'b1;
   logic force_sp = 1'b0;
   logic rx_bit;
   logic frm_grant, frm_abort, frm_fail;

   int n_chk = 0;
   int n_fail = 0;

   assign rx_bit = (frm_grant ? tx_bit : 1'b1) & ~force_sp;

   csma_backoff_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frm_req(frm_req),
      .frm_done(frm_done), .tx_bit(tx_bit), .rx_bit(rx_bit),
      .frm_grant(frm_grant), .frm_abort(frm_abort), .frm_fail(frm_fail)
   );

   initial forever #4 clk = ~clk;

   initial begin
      forever begin
         repeat (2) @(posedge clk);
         #1 bit_tick = 1'b1;
         @(posedge clk);
         #1 bit_tick = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   // behavioural model, evaluated between edges
   int  idle_m = 0, coll_m = 0, kwin = 0, since_ab = -1;
   bit  exp_abort = 0, exp_fail = 0, exp_drop = 0, after_fail = 0;
   bit  pv_req = 0, g_prev = 0, pv_fail_pending = 0;
   int  pv_idle = 0;
   int  n_abort = 0, n_fail_seen = 0, n_grant = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(!frm_grant && !frm_abort && !frm_fail, "R1 outputs low in reset",
             {frm_grant, frm_abort, frm_fail}, 0);
         idle_m = 0; coll_m = 0; since_ab = -1; exp_abort = 0; exp_fail = 0;
         exp_drop = 0; g_prev = 0; pv_req = 0; pv_idle = 0;
      end else begin
         chk(frm_abort == exp_abort, "R4/R5 abort pulse", frm_abort, exp_abort);
         chk(frm_fail == exp_fail, "R8 fail pulse", frm_fail, exp_fail);
         if (exp_drop) chk(!frm_grant, "R4/R7 grant released", frm_grant, 0);
         if (frm_abort) begin
            n_abort++;
            since_ab = 0;
            after_fail = frm_fail;
         end
         if (frm_fail) n_fail_seen++;
         if (frm_grant && !g_prev) begin
            n_grant++;
            chk(pv_req == 1'b1, "R2 grant only on request", pv_req, 1);
            chk(pv_idle >= 11, "R2/R3 eleven Mark ticks before grant", pv_idle, 11);
            if (since_ab >= 0) begin
               if (after_fail)
                  chk(since_ab == 11, "R8 regrant after fail", since_ab, 11);
               else
                  chk((since_ab == 11 || (since_ab % 12 == 0 && since_ab >= 12)) &&
                      since_ab <= ((kwin == 0) ? 11 : 12 * ((1 << kwin) - 1)) + (kwin == 0 ? 0 : 0)
                      && since_ab <= ((12 * ((1 << kwin) - 1)) > 11 ? 12 * ((1 << kwin) - 1) : 11),
                      "R6 backoff window", since_ab, 12 * ((1 << kwin) - 1));
               since_ab = -1;
            end
         end
         g_prev  = frm_grant;
         pv_req  = frm_req;
         pv_idle = idle_m;
         // prediction for the coming edge
         exp_abort = frm_grant && bit_tick && (rx_bit != tx_bit);
         exp_fail  = 0;
         exp_drop  = exp_abort || (frm_grant && frm_done);
         if (exp_abort) begin
            coll_m++;
            if (coll_m == 16) begin
               exp_fail = 1;
               coll_m = 0;
            end
            kwin = (coll_m > 8) ? 8 : coll_m;
         end else if (frm_grant && frm_done) begin
            coll_m = 0;
         end
         if (frm_grant) idle_m = 0;
         else if (bit_tick) idle_m = rx_bit ? idle_m + 1 : 0;
         if (since_ab >= 0 && bit_tick) since_ab++;
      end
   end

   task automatic drive_wait(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_grant();
      while (!frm_grant) @(negedge clk);
      @(posedge clk); #1;
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         while (!bit_tick) @(negedge clk);
         @(posedge clk); #1;
      end
   endtask

   task automatic collide_once();
      wait_grant();
      tx_bit = 1'b1;
      wait_ticks(2);
      force_sp = 1'b1;
      while (!frm_abort) @(negedge clk);
      @(posedge clk); #1;
      force_sp = 1'b0;
   endtask

   task automatic finish_frame();
      wait_grant();
      tx_bit = 1'b0;
      wait_ticks(1);
      tx_bit = 1'b1;
      wait_ticks(1);
      frm_done = 1'b1;
      drive_wait(1);
      frm_done = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      int ab0;
      drive_wait(5);
      rst_n = 1'b1;
      #3 chk(!frm_grant && !frm_abort && !frm_fail, "R1 first cycle after reset",
             {frm_grant, frm_abort, frm_fail}, 0);
      drive_wait(2);

      // R2/R3: request with a Space glitch on the line before the Mark run completes
      frm_req = 1'b1;
      wait_ticks(6);
      force_sp = 1'b1;
      wait_ticks(1);
      force_sp = 1'b0;
      wait_ticks(5);
      chk(!frm_grant, "R3 Space restarted Mark run", frm_grant, 0);

      // R5: own Space read back under another station's Space is no collision
      wait_grant();
      ab0 = n_abort;
      tx_bit = 1'b0;
      force_sp = 1'b1;
      wait_ticks(3);
      force_sp = 1'b0;
      tx_bit = 1'b1;
      wait_ticks(2);
      chk(n_abort == ab0 && frm_grant, "R5 matching levels keep grant", n_abort - ab0, 0);
      frm_done = 1'b1;
      drive_wait(1);
      frm_done = 1'b0;
      frm_req = 1'b0;
      drive_wait(3);
      chk(!frm_grant, "R7 done ends grant", frm_grant, 0);

      // R9-like: no request, no grant
      wait_ticks(20);
      chk(!frm_grant, "R2 no grant without request", frm_grant, 0);

      // R4/R6: several consecutive collisions, then success
      frm_req = 1'b1;
      for (int i = 0; i < 5; i++) collide_once();
      chk(n_abort == ab0 + 5, "R4 five aborts seen", n_abort - ab0, 5);
      finish_frame();
      // R7: count cleared, next collision window is 0..1 slots
      collide_once();
      finish_frame();
      frm_req = 1'b0;
      wait_ticks(3);

      // R8: sixteen consecutive collisions
      frm_req = 1'b1;
      for (int i = 0; i < 16; i++) collide_once();
      chk(n_fail_seen == 1, "R8 one fail pulse", n_fail_seen, 1);
      finish_frame();
      frm_req = 1'b0;
      wait_ticks(3);
      chk(!frm_grant && !frm_abort && !frm_fail, "R7 idle at end",
          {frm_grant, frm_abort, frm_fail}, 0);
      chk(n_grant >= 25, "R6 all retries regranted", n_grant, 25);
      finish_run();
   end
endmodule